// File: doc/BRIEF.md
# Sampling Converter Host Bus Controller

This block is the host-side control logic of a multi-input sampling analog-to-digital converter. To the host it looks like one memory location or I/O port. It has an active-low chip select, an active-low sample strobe, an active-low read strobe and channel-select bits. It drives a parallel result bus with an output enable and an active-low interrupt. The analog engine sits outside the block. The block tells the engine when the coarse phase is active and when the fine phase starts, and which input is in use. The engine answers with a one-cycle done pulse and the result word.

The block has two interface modes, chosen by a static mode input. In separate mode the sample strobe's low time is the sampling window, and its release starts the fine phase. In tied mode the read and sample strobes are one signal. An internal cycle timer then ends the coarse phase. While the strobe is held, the bus keeps showing the previous result until the interrupt falls. All durations are counted in clock cycles and set by parameters.

Top module: `adc_bus_ctrl`

## Requirements
- R1: After reset `int_n` is 1, `db_oe` is 0, `coarse_en` is 0, `fine_start` is 0 and `db_out` is 0.
- R2: While `cs_n` is 1, the sample strobe and the read strobe are ignored. No conversion starts, `db_oe` stays 0, and a read does not clear the interrupt.
- R3: The channel is the value of `sel` on the clock edge where the gated sample strobe first becomes active. The value is used unchanged as `conv_ch`: 0 to 3 pick inputs 0 to 3 (with CHANNELS=2, `sel` is one bit wide).
- R4: In separate mode (`mode_tied`=0), `coarse_en` is 1 for exactly as many cycles as the gated sample strobe stays low. `fine_start` is a one-cycle pulse in the cycle after the strobe is released.
- R5: In tied mode (`mode_tied`=1), `coarse_en` is 1 for exactly COARSE_CYC cycles, whatever the strobe does. `fine_start` then pulses for one cycle.
- R6: A `conv_done` pulse during the fine phase does two things on that same edge: it captures `conv_data` into the result register and drives `int_n` to 0. `db_out` changes only on such an edge.
- R7: `int_n` stays 0 while the gated read is held, and returns to 1 in the cycle after the gated read strobe is released.
- R8: `db_oe` is 1 exactly while `cs_n` and `rd_n` are both 0. `db_out` always shows the last captured result, so in tied mode the bus shows the previous result until `int_n` falls.
- R9: A sample-strobe falling edge while a conversion is in progress is ignored. `conv_ch` and `coarse_en` keep their values, and the running conversion completes with its original channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_tied | input | 1 | 0: separate sample and read strobes, 1: tied strobes with internal coarse timer |
| cs_n | input | 1 | Active-low chip select, gates both strobes |
| sh_n | input | 1 | Active-low sample strobe |
| rd_n | input | 1 | Active-low read strobe |
| sel | input | CH_W | Channel select |
| conv_done | input | 1 | One-cycle pulse from the engine when the result is ready |
| conv_data | input | DATA_W | Result word from the engine |
| coarse_en | output | 1 | Sampling and coarse phase active |
| fine_start | output | 1 | One-cycle pulse starting the fine phase |
| conv_ch | output | CH_W | Channel latched for the current conversion |
| db_out | output | DATA_W | Result bus value |
| db_oe | output | 1 | Result bus output enable (bus is high impedance when 0) |
| int_n | output | 1 | Active-low conversion-complete interrupt |

## Verification
The assertions assume two things about the inputs. First, in separate mode every sample-strobe low pulse lasts at least MIN_SAMPLE cycles. Second, the engine raises `conv_done` only in the fine phase. The bench keeps to both. Its separate-mode pulses run from MIN_SAMPLE to MIN_SAMPLE+2 cycles, and its engine model answers only after it sees `fine_start`, a fixed number of cycles later. Strobes that arrive inside a running conversion are sent only during the fine phase, with lengths at or above the minimum.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SAMPLE = 2'd1,
      PH_FINE   = 2'd2
   } phase_e;

   function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/adc_strobe_edge.sv
module adc_strobe_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sh_n,
   input  logic rd_n,
   output logic sh_act,
   output logic sh_start,
   output logic rd_act,
   output logic rd_end
);

   logic sh_q;
   logic rd_q;

   assign sh_act   = ~cs_n & ~sh_n;
   assign rd_act   = ~cs_n & ~rd_n;
   assign sh_start = sh_act & ~sh_q;
   assign rd_end   = rd_q & ~rd_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= 1'b0;
         rd_q <= 1'b0;
      end else begin
         sh_q <= sh_act;
         rd_q <= rd_act;
      end
   end

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
   import adc_bus_pkg::*;
#(
   parameter int unsigned CH_W       = 2,
   parameter int unsigned COARSE_CYC = 6,
   parameter int unsigned MIN_SAMPLE = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mode_tied,
   input  logic            sh_act,
   input  logic            sh_start,
   input  logic [CH_W-1:0] sel,
   input  logic            conv_done,
   output logic            coarse_en,
   output logic            fine_start,
   output logic [CH_W-1:0] conv_ch,
   output logic            complete
);

   localparam int unsigned LIM = max_of(COARSE_CYC, MIN_SAMPLE);
   localparam int unsigned CW  = $clog2(LIM + 1) + 1;
   localparam logic [CW-1:0] CNT_MAX   = '1;
   localparam logic [CW-1:0] COARSE_LV = CW'(COARSE_CYC);
   localparam logic [CW-1:0] MIN_LV    = CW'(MIN_SAMPLE);

   phase_e          phase;
   logic [CW-1:0]   cnt;
   logic [CH_W-1:0] ch_q;
   logic            fine_q;
   logic            leave_sample;
   logic            busy;

   generate
      if (COARSE_CYC < 1) begin : g_bad_coarse
         $error("COARSE_CYC must be at least 1");
      end
      if (MIN_SAMPLE < 1) begin : g_bad_min
         $error("MIN_SAMPLE must be at least 1");
      end
   endgenerate

   assign leave_sample = mode_tied ? (cnt == COARSE_LV) : ~sh_act;
   assign busy         = (phase != PH_IDLE);
   assign coarse_en    = (phase == PH_SAMPLE);
   assign fine_start   = fine_q;
   assign conv_ch      = ch_q;
   assign complete     = (phase == PH_FINE) & conv_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         cnt    <= '0;
         ch_q   <= '0;
         fine_q <= 1'b0;
      end else begin
         fine_q <= 1'b0;
         case (phase)
            PH_IDLE: begin
               if (sh_start) begin
                  phase <= PH_SAMPLE;
                  cnt   <= CW'(1);
                  ch_q  <= sel;
               end
            end
            PH_SAMPLE: begin
               if (leave_sample) begin
                  phase  <= PH_FINE;
                  fine_q <= 1'b1;
               end else if (cnt != CNT_MAX) begin
                  cnt <= cnt + CW'(1);
               end
            end
            PH_FINE: begin
               if (conv_done) begin
                  phase <= PH_IDLE;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // R4
   fine_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fine_start |=> !fine_start);

   // R9
   ch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(conv_ch));

   // R4 (input assumption: minimum sample pulse in separate mode)
   min_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SAMPLE && !mode_tied && !sh_act) |-> (cnt >= MIN_LV));

endmodule

// File: rtl/adc_result_port.sv
module adc_result_port #(
   parameter int unsigned DATA_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              complete,
   input  logic [DATA_W-1:0] conv_data,
   input  logic              rd_act,
   input  logic              rd_end,
   output logic [DATA_W-1:0] db_out,
   output logic              db_oe,
   output logic              int_n
);

   logic [DATA_W-1:0] result_q;
   logic              int_q;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
   endgenerate

   assign db_out = result_q;
   assign db_oe  = rd_act;
   assign int_n  = int_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_q <= '0;
         int_q    <= 1'b1;
      end else begin
         if (complete) begin
            result_q <= conv_data;
            int_q    <= 1'b0;
         end else if (rd_end) begin
            int_q <= 1'b1;
         end
      end
   end

   // R6
   bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !complete |=> $stable(db_out));

   // R7
   int_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_n) |-> $past(rd_end));

endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl #(
   parameter int unsigned CHANNELS   = 4,
   parameter int unsigned DATA_W     = 10,
   parameter int unsigned COARSE_CYC = 6,
   parameter int unsigned MIN_SAMPLE = 3,
   localparam int unsigned CH_W      = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_tied,
   input  logic              cs_n,
   input  logic              sh_n,
   input  logic              rd_n,
   input  logic [CH_W-1:0]   sel,
   input  logic              conv_done,
   input  logic [DATA_W-1:0] conv_data,
   output logic              coarse_en,
   output logic              fine_start,
   output logic [CH_W-1:0]   conv_ch,
   output logic [DATA_W-1:0] db_out,
   output logic              db_oe,
   output logic              int_n
);

   logic sh_act;
   logic sh_start;
   logic rd_act;
   logic rd_end;
   logic complete;

   generate
      if (CHANNELS != 2 && CHANNELS != 4) begin : g_bad_channels
         $error("CHANNELS must be 2 or 4");
      end
   endgenerate

   adc_strobe_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n     (cs_n),
      .sh_n     (sh_n),
      .rd_n     (rd_n),
      .sh_act   (sh_act),
      .sh_start (sh_start),
      .rd_act   (rd_act),
      .rd_end   (rd_end)
   );

   adc_conv_seq #(
      .CH_W       (CH_W),
      .COARSE_CYC (COARSE_CYC),
      .MIN_SAMPLE (MIN_SAMPLE)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_tied  (mode_tied),
      .sh_act     (sh_act),
      .sh_start   (sh_start),
      .sel        (sel),
      .conv_done  (conv_done),
      .coarse_en  (coarse_en),
      .fine_start (fine_start),
      .conv_ch    (conv_ch),
      .complete   (complete)
   );

   adc_result_port #(
      .DATA_W (DATA_W)
   ) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .complete  (complete),
      .conv_data (conv_data),
      .rd_act    (rd_act),
      .rd_end    (rd_end),
      .db_out    (db_out),
      .db_oe     (db_oe),
      .int_n     (int_n)
   );

   // R2
   cs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(coarse_en) |-> $past(!cs_n && !sh_n));

   // R6
   int_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(int_n) |-> $past(conv_done));

endmodule

// File: tb/adc_bus_ctrl_tb_top.sv
module adc_bus_ctrl_tb_top;

   localparam int CH   = 4;
   localparam int DW   = 10;
   localparam int CC   = 6;
   localparam int MS   = 3;
   localparam int LAT  = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_tied = 1'b0;
   logic          cs_n = 1'b1;
   logic          sh_n = 1'b1;
   logic          rd_n = 1'b1;
   logic [1:0]    sel = '0;
   logic          conv_done = 1'b0;
   logic [DW-1:0] conv_data = '0;
   logic          coarse_en;
   logic          fine_start;
   logic [1:0]    conv_ch;
   logic [DW-1:0] db_out;
   logic          db_oe;
   logic          int_n;

   int total = 0;
   int bad = 0;
   int eng_idx = 0;
   int exp_idx = 0;
   int last_res = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   adc_bus_ctrl #(
      .CHANNELS(CH), .DATA_W(DW), .COARSE_CYC(CC), .MIN_SAMPLE(MS)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .mode_tied(mode_tied), .cs_n(cs_n),
      .sh_n(sh_n), .rd_n(rd_n), .sel(sel), .conv_done(conv_done),
      .conv_data(conv_data), .coarse_en(coarse_en), .fine_start(fine_start),
      .conv_ch(conv_ch), .db_out(db_out), .db_oe(db_oe), .int_n(int_n)
   );

   function automatic int code_of(input int ch, input int k);
      return (ch * 256 + k * 37 + 5) % 1024;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // engine model: answers LAT cycles after fine_start with a code for conv_ch
   initial begin
      forever begin
         @(negedge clk);
         if (fine_start) begin
            automatic int ch = int'(conv_ch);
            repeat (LAT - 1) @(negedge clk);
            conv_data = DW'(code_of(ch, eng_idx));
            conv_done = 1'b1;
            @(negedge clk);
            conv_done = 1'b0;
            eng_idx++;
         end
      end
   end

   task automatic wait_int(input string req);
      int n;
      n = 0;
      while (int_n !== 1'b0 && n < 100) begin
         @(negedge clk);
         n++;
      end
      chk(req, int'(int_n), 0);
   endtask

   task automatic read_out(input int exp);
      rd_n = 1'b0; cs_n = 1'b0;
      @(negedge clk);
      chk("R8 db_oe during read", int'(db_oe), 1);
      chk("R6 result value", int'(db_out), exp);
      chk("R7 int held during read", int'(int_n), 0);
      rd_n = 1'b1; cs_n = 1'b1;
      @(negedge clk);
      chk("R7 int cleared after read", int'(int_n), 1);
      chk("R8 db_oe after read", int'(db_oe), 0);
      chk("R8 bus keeps result", int'(db_out), exp);
   endtask

   task automatic sep_conv(input int ch, input int len, input bit poke);
      int cnt;
      int exp;
      sel = 2'(ch); cs_n = 1'b0; sh_n = 1'b0;
      cnt = 0;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         if (coarse_en) cnt++;
      end
      sh_n = 1'b1; cs_n = 1'b1; sel = 2'(ch ^ 3);
      @(negedge clk);
      chk("R4 coarse cycles", cnt, len);
      chk("R4 fine_start pulse", int'(fine_start), 1);
      chk("R4 coarse off", int'(coarse_en), 0);
      chk("R3 channel latched", int'(conv_ch), ch);
      @(negedge clk);
      chk("R4 fine_start one cycle", int'(fine_start), 0);
      if (poke) begin
         sel = 2'(ch ^ 1); cs_n = 1'b0; sh_n = 1'b0;
         for (int i = 0; i < MS; i++) begin
            @(negedge clk);
            chk("R9 channel kept", int'(conv_ch), ch);
            chk("R9 no restart", int'(coarse_en), 0);
         end
         sh_n = 1'b1; cs_n = 1'b1;
      end
      exp = code_of(ch, exp_idx);
      exp_idx++;
      wait_int("R6 interrupt falls");
      chk("R6 bus updated at completion", int'(db_out), exp);
      if (poke) begin
         rd_n = 1'b0; cs_n = 1'b1;
         @(negedge clk);
         chk("R2 no bus without cs", int'(db_oe), 0);
         rd_n = 1'b1;
         @(negedge clk);
         chk("R2 read without cs keeps int", int'(int_n), 0);
      end
      read_out(exp);
      last_res = exp;
   endtask

   task automatic tied_conv(input int ch);
      int cnt;
      int exp;
      sel = 2'(ch); cs_n = 1'b0; sh_n = 1'b0; rd_n = 1'b0;
      cnt = 0;
      @(negedge clk);
      while (!fine_start && cnt < 50) begin
         if (coarse_en) cnt++;
         chk("R8 previous result shown", int'(db_out), last_res);
         @(negedge clk);
      end
      chk("R5 coarse timer cycles", cnt, CC);
      chk("R3 channel latched", int'(conv_ch), ch);
      exp = code_of(ch, exp_idx);
      exp_idx++;
      while (int_n && cnt < 200) begin
         chk("R8 previous result until int", int'(db_out), last_res);
         chk("R8 bus driven while held", int'(db_oe), 1);
         @(negedge clk);
         cnt++;
      end
      chk("R6 interrupt falls", int'(int_n), 0);
      chk("R6 new result at int", int'(db_out), exp);
      @(negedge clk);
      chk("R7 int held while strobe low", int'(int_n), 0);
      chk("R5 no restart while held", int'(coarse_en), 0);
      sh_n = 1'b1; rd_n = 1'b1; cs_n = 1'b1;
      @(negedge clk);
      chk("R7 int cleared after release", int'(int_n), 1);
      last_res = exp;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 int_n", int'(int_n), 1);
      chk("R1 db_oe", int'(db_oe), 0);
      chk("R1 coarse_en", int'(coarse_en), 0);
      chk("R1 fine_start", int'(fine_start), 0);
      chk("R1 db_out", int'(db_out), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2: strobes with chip select high
      cs_n = 1'b1; sh_n = 1'b0; rd_n = 1'b0;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk("R2 no sample without cs", int'(coarse_en), 0);
         chk("R2 no bus without cs", int'(db_oe), 0);
      end
      sh_n = 1'b1; rd_n = 1'b1;
      @(negedge clk);
      chk("R2 no fine without cs", int'(fine_start), 0);
      // R3 R4 R6 R7 R8: separate mode sweep
      mode_tied = 1'b0;
      for (int ch = 0; ch < CH; ch++)
         for (int len = MS; len < MS + 3; len++)
            sep_conv(ch, len, 1'b0);
      // R9: strobe during conversion
      sep_conv(1, MS, 1'b1);
      sep_conv(2, MS + 1, 1'b1);
      // R5 R8: tied mode sweep
      @(negedge clk);
      mode_tied = 1'b1;
      for (int ch = 0; ch < CH; ch++) tied_conv(ch);
      tied_conv(3);
      @(negedge clk);
      mode_tied = 1'b0;
      sep_conv(0, MS, 1'b0);
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule